// File: doc/BRIEF.md
# Nonvolatile Write Gatekeeper

This block sits between a serial bus decoder and the nonvolatile write engine of a small serial EEPROM. For every bus transaction it decides whether a nonvolatile write cycle may begin. It emits either a one-cycle commit pulse that starts the write engine, or a one-cycle abort pulse that tells the bus logic the request was refused.

A write is allowed only when every protection layer agrees:
- a volatile write-enable latch has been set;
- the transaction ended with a clean stop after the exact clock count for its length;
- the hardware protect pin is low;
- the supply is not in its low state;
- the target address is not in a region the lock setting has made read-only;
- for the control register only, a three-step unlock has completed.

The bus decoder supplies pulses for start and stop, plus the bit-clock and byte counts of the current transaction. It also supplies the target address, a control-register select, the transfer direction and the first data byte.

Top module: `wprot_guard`

## Requirements
- R1: A well-formed array write (wrDir=1, ctrlSel=0) commits only if the write-enable latch is set; otherwise it produces an abort pulse.
- R2: A stop is well-formed only when bitCount equals 9 times byteCount and byteCount is legal: 1 or more for a read, exactly 3 for a control write, 3 to 18 for an array write. Any other stop is ignored: there is no pulse, and the latch and the unlock step are unchanged.
- R3: A control write commits only as the third step of an unlock. The first step writes data 0x02, which sets the latch. The second step writes data 0x06. The third step writes any other byte, and its bits [4:3] become the lock field. A control write out of this order aborts and returns the unlock to step one.
- R4: While wpPin is high, array writes and the third unlock step abort. The latch is kept after such an abort.
- R5: lowSupply passes through a two-flop synchronizer. Once it is seen, a transaction in progress ends with an abort pulse on the third clock edge after lowSupply rises. While it stays high, starts and stops are ignored.
- R6: Lock field 00 protects nothing. 01 protects addresses at or above 3/4 of the array (0x180 to 0x1FF). 10 protects the upper half (0x100 to 0x1FF). 11 protects the whole array. A write to a protected address aborts.
- R7: The write-enable latch clears after any commit and on a synchronized low-supply event.
- R8: commitPulse and abortPulse are high for a single cycle, on the clock after the edge that samples busStop, and never together.
- R9: After reset both outputs are low, the latch is clear, the lock field is 00 and the unlock is at step one.
- R10: A well-formed read causes no pulse and returns the unlock to step one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busStart | input | 1 | Start condition pulse |
| busStop | input | 1 | Stop condition pulse |
| bitCount | input | 10 | Bit clocks seen in the transaction |
| byteCount | input | 6 | Bytes received including the slave byte |
| memAddr | input | 9 | Target array address |
| ctrlSel | input | 1 | Transaction targets the control register |
| wrDir | input | 1 | 1 for a write, 0 for a read |
| dataByte | input | 8 | First data byte of the transaction |
| wpPin | input | 1 | Hardware write-protect pin |
| lowSupply | input | 1 | Supply-below-trip comparator, asynchronous |
| commitPulse | output | 1 | Start one nonvolatile write cycle |
| abortPulse | output | 1 | Request refused or terminated |

## Verification
The bench sends stops that are one clock short and that carry too many bytes. A design that does not check the exact count would commit these, or would drop its latch on them. It breaks the unlock with a read and with a second enable write, and it tries the third step with the pin high. A sequencer that forgets its step on these would let a control write through. Writes land at the edges of each lock region (0x17F/0x180, 0x0FF/0x100, 0x000), so an off-by-one region compare would commit or abort on the wrong side. A low-supply event is raised both during a transaction and between transactions. A design that failed to abort, or kept its latch, would show a stray commit afterwards.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic loadLock;
  } dp_strobe_t;

  typedef enum logic [1:0] {STEP_ONE, STEP_TWO, STEP_THREE} unlock_step_t;

  typedef enum logic [1:0] {
    LOCK_NONE    = 2'b00,
    LOCK_QUARTER = 2'b01,
    LOCK_HALF    = 2'b10,
    LOCK_ALL     = 2'b11
  } lock_t;

  localparam logic [7:0] CMD_SET_WEL  = 8'h02;
  localparam logic [7:0] CMD_SET_RWEL = 8'h06;
  localparam int LOCK_LSB = 3;
endpackage

// File: rtl/wprot_datapath.sv
module wprot_datapath
  import wprot_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int BYTE_W      = 6,
  parameter int BIT_W       = 10,
  parameter int HDR_BYTES   = 2,
  parameter int PAGE_BYTES  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        strobe,
  input  logic [7:0]        dataByte,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic              ctrlSel,
  input  logic              wrDir,
  input  logic [BYTE_W-1:0] byteCount,
  input  logic [BIT_W-1:0]  bitCount,
  input  logic              lowSupply,
  output logic              welQ,
  output logic              lowSync,
  output logic              frameOk,
  output logic              addrLocked,
  output logic              isWelCmd,
  output logic              isRwelCmd
);
  localparam int MIN_WR_BYTES = HDR_BYTES + 1;
  localparam int MAX_WR_BYTES = HDR_BYTES + PAGE_BYTES;
  localparam int ARRAY_SIZE   = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] QUARTER_BASE = ADDR_W'((ARRAY_SIZE / 4) * 3);
  localparam logic [ADDR_W-1:0] HALF_BASE    = ADDR_W'(ARRAY_SIZE / 2);

  logic [SYNC_STAGES-1:0] syncQ;
  lock_t lockQ;
  logic bitsMatch, rangeOk;

  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], lowSupply};
  end
  assign lowSync = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN)               welQ <= 1'b0;
    else if (strobe.clrWel)  welQ <= 1'b0;
    else if (strobe.setWel)  welQ <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                lockQ <= LOCK_NONE;
    else if (strobe.loadLock) lockQ <= lock_t'(dataByte[LOCK_LSB+1:LOCK_LSB]);
  end

  always_comb begin
    bitsMatch = (bitCount == BIT_W'(byteCount) * BIT_W'(9));
    if (!wrDir)       rangeOk = (byteCount != '0);
    else if (ctrlSel) rangeOk = (byteCount == BYTE_W'(MIN_WR_BYTES));
    else              rangeOk = (byteCount >= BYTE_W'(MIN_WR_BYTES)) &&
                                (byteCount <= BYTE_W'(MAX_WR_BYTES));
    frameOk = bitsMatch && rangeOk;
  end

  always_comb begin
    unique case (lockQ)
      LOCK_NONE:    addrLocked = 1'b0;
      LOCK_QUARTER: addrLocked = (memAddr >= QUARTER_BASE);
      LOCK_HALF:    addrLocked = (memAddr >= HALF_BASE);
      default:      addrLocked = 1'b1;
    endcase
  end

  assign isWelCmd  = (dataByte == CMD_SET_WEL);
  assign isRwelCmd = (dataByte == CMD_SET_RWEL);

  // R6: the lock field follows the data byte of the committed third step
  p_lock_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadLock |=> lockQ == lock_t'($past(dataByte[LOCK_LSB+1:LOCK_LSB])));
  // R7: a synchronized low-supply event leaves the latch clear
  p_low_clears_wel_r7: assert property (@(posedge clk) disable iff (!rstN)
    lowSync |=> !welQ);
endmodule

// File: rtl/wprot_ctrl.sv
module wprot_ctrl
  import wprot_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busStart,
  input  logic       busStop,
  input  logic       ctrlSel,
  input  logic       wrDir,
  input  logic       wpPin,
  input  logic       welQ,
  input  logic       lowSync,
  input  logic       frameOk,
  input  logic       addrLocked,
  input  logic       isWelCmd,
  input  logic       isRwelCmd,
  output dp_strobe_t strobe,
  output logic       commitPulse,
  output logic       abortPulse
);
  unlock_step_t stepQ, stepD;
  logic activeQ, activeD, commitD, abortD;

  always_comb begin
    strobe  = '0;
    commitD = 1'b0;
    abortD  = 1'b0;
    stepD   = stepQ;
    activeD = activeQ;
    if (lowSync) begin
      strobe.clrWel = 1'b1;
      stepD   = STEP_ONE;
      activeD = 1'b0;
      abortD  = activeQ;
    end else if (activeQ && busStop) begin
      activeD = 1'b0;
      if (frameOk) begin
        stepD = STEP_ONE;
        if (wrDir && ctrlSel) begin
          if (isWelCmd) begin
            strobe.setWel = 1'b1;
            stepD = STEP_TWO;
          end else if (isRwelCmd && stepQ == STEP_TWO && welQ) begin
            stepD = STEP_THREE;
          end else if (stepQ == STEP_THREE && welQ && !wpPin) begin
            strobe.loadLock = 1'b1;
            strobe.clrWel   = 1'b1;
            commitD = 1'b1;
          end else begin
            abortD = 1'b1;
          end
        end else if (wrDir) begin
          if (welQ && !wpPin && !addrLocked) begin
            strobe.clrWel = 1'b1;
            commitD = 1'b1;
          end else begin
            abortD = 1'b1;
          end
        end
      end
    end else if (busStart) begin
      activeD = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepQ       <= STEP_ONE;
      activeQ     <= 1'b0;
      commitPulse <= 1'b0;
      abortPulse  <= 1'b0;
    end else begin
      stepQ       <= stepD;
      activeQ     <= activeD;
      commitPulse <= commitD;
      abortPulse  <= abortD;
    end
  end

  // R1: a commit requires the latch to have been set
  p_commit_wel_r1: assert property (@(posedge clk) disable iff (!rstN)
    commitPulse |-> $past(welQ));
  // R2: a commit follows a well-formed stop
  p_commit_stop_r2: assert property (@(posedge clk) disable iff (!rstN)
    commitPulse |-> ($past(busStop) && $past(frameOk)));
  // R3: a control commit needs the armed third step
  p_ctrl_armed_r3: assert property (@(posedge clk) disable iff (!rstN)
    (commitPulse && $past(ctrlSel)) |-> $past(stepQ) == STEP_THREE);
  // R4: the protect pin blocks every commit
  p_commit_wp_r4: assert property (@(posedge clk) disable iff (!rstN)
    commitPulse |-> !$past(wpPin));
  // R5: no commit while the supply is low
  p_commit_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    commitPulse |-> !$past(lowSync));
  // R6: an array commit never targets a locked address
  p_commit_lock_r6: assert property (@(posedge clk) disable iff (!rstN)
    (commitPulse && !$past(ctrlSel)) |-> !$past(addrLocked));
  // R7: the latch is clear once a commit has been issued
  p_commit_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    commitPulse |-> !welQ);
  // R8: single-cycle pulses, never together
  p_commit_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    commitPulse |=> !commitPulse);
  p_abort_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |=> !abortPulse);
  p_exclusive_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(commitPulse && abortPulse));
endmodule

// File: rtl/wprot_guard.sv
module wprot_guard
  import wprot_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int BYTE_W     = 6,
  parameter int HDR_BYTES  = 2,
  parameter int PAGE_BYTES = 16,
  parameter int BIT_W      = BYTE_W + 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busStart,
  input  logic              busStop,
  input  logic [BIT_W-1:0]  bitCount,
  input  logic [BYTE_W-1:0] byteCount,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic              ctrlSel,
  input  logic              wrDir,
  input  logic [7:0]        dataByte,
  input  logic              wpPin,
  input  logic              lowSupply,
  output logic              commitPulse,
  output logic              abortPulse
);
  dp_strobe_t strobe;
  logic welQ, lowSync, frameOk, addrLocked, isWelCmd, isRwelCmd;

  wprot_datapath #(
    .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .BIT_W(BIT_W),
    .HDR_BYTES(HDR_BYTES), .PAGE_BYTES(PAGE_BYTES), .SYNC_STAGES(2)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dataByte(dataByte),
    .memAddr(memAddr), .ctrlSel(ctrlSel), .wrDir(wrDir),
    .byteCount(byteCount), .bitCount(bitCount), .lowSupply(lowSupply),
    .welQ(welQ), .lowSync(lowSync), .frameOk(frameOk),
    .addrLocked(addrLocked), .isWelCmd(isWelCmd), .isRwelCmd(isRwelCmd)
  );

  wprot_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busStart(busStart), .busStop(busStop),
    .ctrlSel(ctrlSel), .wrDir(wrDir), .wpPin(wpPin), .welQ(welQ),
    .lowSync(lowSync), .frameOk(frameOk), .addrLocked(addrLocked),
    .isWelCmd(isWelCmd), .isRwelCmd(isRwelCmd), .strobe(strobe),
    .commitPulse(commitPulse), .abortPulse(abortPulse)
  );
endmodule

// File: tb/wprot_guard_bench.sv
`timescale 1ns/1ps
module wprot_guard_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busStart = 1'b0, busStop = 1'b0;
  logic [9:0] bitCount = '0;
  logic [5:0] byteCount = '0;
  logic [8:0] memAddr = '0;
  logic ctrlSel = 1'b0, wrDir = 1'b0, wpPin = 1'b0, lowSupply = 1'b0;
  logic [7:0] dataByte = '0;
  logic commitPulse, abortPulse;
  int checks = 0, fails = 0;

  localparam logic [1:0] NONE = 2'b00, COMMIT = 2'b10, ABORT = 2'b01;

  always #2 clk = ~clk;

  wprot_guard u_wprot_guard (
    .clk(clk), .rstN(rstN), .busStart(busStart), .busStop(busStop),
    .bitCount(bitCount), .byteCount(byteCount), .memAddr(memAddr),
    .ctrlSel(ctrlSel), .wrDir(wrDir), .dataByte(dataByte), .wpPin(wpPin),
    .lowSupply(lowSupply), .commitPulse(commitPulse), .abortPulse(abortPulse)
  );

  task automatic chk(input string tag, input logic [1:0] got, input logic [1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got commit/abort=%b expected %b", tag, got, exp);
    end
  endtask

  // one transaction; returns {commit,abort} sampled the cycle after stop
  task automatic xact(input logic c, input logic w, input logic [8:0] a,
                      input logic [7:0] d, input int nb, input int nbits,
                      output logic [1:0] res);
    @(negedge clk);
    ctrlSel = c; wrDir = w; memAddr = a; dataByte = d;
    byteCount = 6'(nb); bitCount = 10'(nbits); busStart = 1'b1;
    @(negedge clk); busStart = 1'b0;
    @(negedge clk); busStop = 1'b1;
    @(negedge clk); busStop = 1'b0;
    res = {commitPulse, abortPulse};
  endtask

  task automatic arrWr(input logic [8:0] a, output logic [1:0] res);
    xact(1'b0, 1'b1, a, 8'h55, 3, 27, res);
  endtask
  task automatic ctrlWr(input logic [7:0] d, output logic [1:0] res);
    xact(1'b1, 1'b1, 9'h0, d, 3, 27, res);
  endtask
  task automatic setLock(input logic [1:0] code, input string tag);
    logic [1:0] r;
    ctrlWr(8'h02, r); chk({tag, " step1"}, r, NONE);
    ctrlWr(8'h06, r); chk({tag, " step2"}, r, NONE);
    ctrlWr({3'b000, code, 3'b000}, r); chk({tag, " step3"}, r, COMMIT);
  endtask

  task automatic t_reset;
    logic [1:0] r;
    @(negedge clk);
    chk("R9 outputs low after reset", {commitPulse, abortPulse}, NONE);
    arrWr(9'h000, r); chk("R9 latch clear after reset", r, ABORT);
  endtask

  task automatic t_wel;
    logic [1:0] r;
    arrWr(9'h010, r); chk("R1 write without latch", r, ABORT);
    ctrlWr(8'h02, r); chk("R1 latch set", r, NONE);
    arrWr(9'h010, r); chk("R1 write with latch", r, COMMIT);
    @(negedge clk);
    chk("R8 commit lasts one cycle", {commitPulse, abortPulse}, NONE);
    arrWr(9'h010, r); chk("R7 latch cleared by commit", r, ABORT);
  endtask

  task automatic t_badcount;
    logic [1:0] r;
    ctrlWr(8'h02, r);
    xact(1'b0, 1'b1, 9'h020, 8'h11, 3, 26, r); chk("R2 short clock count", r, NONE);
    xact(1'b0, 1'b1, 9'h020, 8'h11, 19, 171, r); chk("R2 too many bytes", r, NONE);
    xact(1'b1, 1'b1, 9'h000, 8'h06, 3, 28, r); chk("R2 bad control count", r, NONE);
    arrWr(9'h020, r); chk("R2 latch kept after ignored stop", r, COMMIT);
    ctrlWr(8'h02, r);
    xact(1'b0, 1'b1, 9'h020, 8'h11, 18, 162, r); chk("R2 full page write", r, COMMIT);
  endtask

  task automatic t_wp;
    logic [1:0] r;
    ctrlWr(8'h02, r);
    wpPin = 1'b1;
    arrWr(9'h030, r); chk("R4 pin blocks array write", r, ABORT);
    wpPin = 1'b0;
    arrWr(9'h030, r); chk("R4 latch kept after pin abort", r, COMMIT);
    ctrlWr(8'h02, r); ctrlWr(8'h06, r);
    wpPin = 1'b1;
    ctrlWr(8'h18, r); chk("R4 pin blocks control write", r, ABORT);
    wpPin = 1'b0;
  endtask

  task automatic t_unlock;
    logic [1:0] r;
    ctrlWr(8'h18, r); chk("R3 control write without unlock", r, ABORT);
    ctrlWr(8'h02, r);
    xact(1'b0, 1'b0, 9'h0, 8'h00, 4, 36, r); chk("R10 read gives no pulse", r, NONE);
    ctrlWr(8'h06, r); chk("R10 read resets unlock", r, ABORT);
    ctrlWr(8'h02, r); ctrlWr(8'h02, r); chk("R3 repeated step1", r, NONE);
    ctrlWr(8'h18, r); chk("R3 skipped step2", r, ABORT);
  endtask

  task automatic t_locks;
    logic [1:0] r;
    setLock(2'b01, "R3 quarter");
    ctrlWr(8'h02, r); arrWr(9'h180, r); chk("R6 quarter base locked", r, ABORT);
    arrWr(9'h17F, r); chk("R6 below quarter open", r, COMMIT);
    setLock(2'b10, "R3 half");
    ctrlWr(8'h02, r); arrWr(9'h100, r); chk("R6 half base locked", r, ABORT);
    arrWr(9'h0FF, r); chk("R6 below half open", r, COMMIT);
    setLock(2'b11, "R3 all");
    ctrlWr(8'h02, r); arrWr(9'h000, r); chk("R6 whole array locked", r, ABORT);
    setLock(2'b00, "R3 none");
    ctrlWr(8'h02, r); arrWr(9'h1FF, r); chk("R6 no lock top open", r, COMMIT);
  endtask

  task automatic t_low;
    logic [1:0] r;
    ctrlWr(8'h02, r);
    @(negedge clk); ctrlSel = 1'b0; wrDir = 1'b1; memAddr = 9'h040;
    byteCount = 6'd3; bitCount = 10'd27; busStart = 1'b1;
    @(negedge clk); busStart = 1'b0; lowSupply = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    chk("R5 no abort before sync", {commitPulse, abortPulse}, NONE);
    @(negedge clk);
    chk("R5 low supply aborts transaction", {commitPulse, abortPulse}, ABORT);
    @(negedge clk); busStop = 1'b1;
    @(negedge clk); busStop = 1'b0;
    chk("R5 stop after abort ignored", {commitPulse, abortPulse}, NONE);
    xact(1'b0, 1'b1, 9'h040, 8'h00, 3, 27, r); chk("R5 transaction while low ignored", r, NONE);
    lowSupply = 1'b0;
    repeat (4) @(negedge clk);
    arrWr(9'h040, r); chk("R7 latch cleared by low supply", r, ABORT);
    ctrlWr(8'h02, r);
    @(negedge clk); lowSupply = 1'b1;
    repeat (4) @(negedge clk);
    lowSupply = 1'b0;
    repeat (4) @(negedge clk);
    arrWr(9'h040, r); chk("R7 idle low event clears latch", r, ABORT);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_wel();
    t_badcount();
    t_wp();
    t_unlock();
    t_locks();
    t_low();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule